// File: doc/BRIEF.md
# Host Command Issue Sequencer with CRC-6 Protected Handshake

This block sits on the host side of a 16-bit register bus and runs one firmware command at a time on a slave device. When started, it writes an encoded length/return word, then an encoded control word whose top bit starts the command. It then polls the control word at a fixed cycle interval until the busy bit drops. After that it reads back the control word and the length/return word, checks the 6-bit CRC spread across them, and reports either a signed 11-bit firmware result or an error status.

Both outgoing words carry a CRC-6 over the command identifier and the length, so the slave can reject corrupted commands. Incoming words carry one as well, so the host can reject corrupted replies. A local CRC mismatch, or one of two reserved result codes with which the slave reports that it saw a corrupted command or payload, sets a sticky error latch. Only the transition of that latch from clear to set emits a one-cycle shutdown request. Software clears the latch to re-arm it. The register access port is a plain request/acknowledge interface. Serial framing on the wire is handled elsewhere.

Top module: `cmd_issue_seq`

## Requirements
- R1: After reset `busy`, `done`, `bus_req`, `shutdown_req` and `crc_latched` are all 0.
- R2: The first transaction of a command is a write to address LEN_ADDR (1) of `{1'b1, 1'b1, crc[3:0], len[9:0]}`. Here crc is the CRC-6 with polynomial x^6+x^5+x^3+x^2+x+1 (0x2F) and initial value 0. It is taken over the four bytes of `{6'b0, len[9:0], pre[15:0]}`, lowest byte first, each byte most significant bit first, where `pre = {3'b111, id[12:0]}`.
- R3: The second transaction is a write to address CTRL_ADDR (0) of `{1'b1, crc[5:4], id[12:0]}`. Bit 15 set starts the command.
- R4: After the control write the block waits at least POLL_GAP cycles before each read of CTRL_ADDR. A read with bit 15 at 0 ends the polling.
- R5: If POLL_LIMIT consecutive polls all read bit 15 as 1, the command ends with status 2 (timeout) and result 0.
- R6: After polling ends, CTRL_ADDR is read and then LEN_ADDR. Call the values c and l. The received CRC is `{c[14:13], l[13:10]}`. It is checked against the CRC-6 of R2 computed over `{c[15], l[14], l[15], c[12:0]}` and `l[9:0]`. On a match the status is 0 and the result is the signed 11-bit value `{l[14], l[9:0]}`.
- R7: A CRC mismatch on the reply ends the command with status 1 and result 0.
- R8: An acknowledged transaction with `bus_err` high ends the command at once with status 3 and result 0. No further transaction of that command is issued.
- R9: A status of 1, or a status of 0 with result -1024 (11'h400) or -1023 (11'h401), sets `crc_latched`. `shutdown_req` is high for exactly the `done` cycle, and only if the latch was clear before.
- R10: `crc_latched` stays set until `crc_clr` is high for a cycle. It reads 0 in the following cycle unless a new event completes in that same cycle.
- R11: `start` while `busy` is high is ignored. No second command is issued and no extra `done` appears.
- R12: A zero-length command (id 8, length 0) is encoded per R2/R3 with a length field of 0 and completes normally.
- R13: `busy` rises in the cycle after an accepted `start`. `done` is a single-cycle pulse, during which `busy` is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a command (accepted when idle) |
| cmd_id | input | 13 | Command identifier |
| cmd_len | input | 10 | Parameter length in bytes |
| crc_clr | input | 1 | Clear the CRC error latch |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 reply CRC error, 2 timeout, 3 bus error |
| result | output | 11 | Signed firmware result (valid with status 0) |
| crc_latched | output | 1 | Sticky CRC error latch |
| shutdown_req | output | 1 | One-cycle shutdown request on first latch set |
| bus_req | output | 1 | Register transaction request, held until ack |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Transaction acknowledge |
| bus_err | input | 1 | Transaction error, valid with ack |
| bus_rdata | input | 16 | Read data, valid with ack |

## Verification
A wrong sequencer state shows up on the bus port within one transaction. The slave sees a write out of order, a wrong encoded word, a poll issued before the gap has passed, or a poll count that differs from the limit. Each of these is flagged on the cycle the transaction is acknowledged. A wrong verify or latch decision only shows on the `done` cycle, as a status, result or shutdown pulse that differs from the queued expectation. The latch and its one-shot behaviour are followed across back-to-back error commands and clears, so a latch that loses or keeps state wrongly is caught at the next completion.

// File: rtl/cmd_issue_pkg.sv
package cmd_issue_pkg;

    typedef enum logic [1:0] {
        STS_OK  = 2'd0,
        STS_CRC = 2'd1,
        STS_TMO = 2'd2,
        STS_BUS = 2'd3
    } cmd_status_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WR_LEN,
        SQ_WR_CTRL,
        SQ_GAP,
        SQ_POLL,
        SQ_RD_CTRL,
        SQ_RD_LEN
    } seq_state_e;

    localparam logic [10:0] FW_CMD_CRC_BAD = 11'h400;
    localparam logic [10:0] FW_PAY_CRC_BAD = 11'h401;

    // Byte-wise CRC-6 (x^6+x^5+x^3+x^2+x+1), 8-bit aligned register form.
    function automatic logic [5:0] crc6_calc(input logic [15:0] word_c,
                                             input logic [9:0]  word_l);
        logic [31:0] dat;
        logic [5:0]  crc;
        logic [7:0]  r;
        dat = {6'b0, word_l, word_c};
        crc = 6'd0;
        for (int b = 0; b < 4; b++) begin
            r = {crc, 2'b00} ^ dat[8*b +: 8];
            for (int k = 0; k < 8; k++) begin
                r = r[7] ? ({r[6:0], 1'b0} ^ 8'hBC) : {r[6:0], 1'b0};
            end
            crc = r[7:2];
        end
        return crc;
    endfunction

endpackage

// File: rtl/cmd_crc6_codec.sv
module cmd_crc6_codec
    import cmd_issue_pkg::*;
(
    input  logic [12:0] id_i,
    input  logic [9:0]  len_i,
    input  logic [15:0] rsp_ctrl_i,
    input  logic [15:0] rsp_len_i,
    output logic [15:0] enc_ctrl_o,
    output logic [15:0] enc_len_o,
    output logic        rsp_ok_o,
    output logic [10:0] rsp_val_o
);
    logic [15:0] pre_ctrl;
    logic [5:0]  tx_crc;
    logic [15:0] rebuilt_ctrl;
    logic [5:0]  rx_crc;
    logic [5:0]  chk_crc;

    always_comb begin
        pre_ctrl     = {3'b111, id_i};
        tx_crc       = crc6_calc(pre_ctrl, len_i);
        enc_ctrl_o   = {1'b1, tx_crc[5:4], id_i};
        enc_len_o    = {2'b11, tx_crc[3:0], len_i};

        rx_crc       = {rsp_ctrl_i[14:13], rsp_len_i[13:10]};
        rebuilt_ctrl = {rsp_ctrl_i[15], rsp_len_i[14], rsp_len_i[15], rsp_ctrl_i[12:0]};
        chk_crc      = crc6_calc(rebuilt_ctrl, rsp_len_i[9:0]);
        rsp_ok_o     = (rx_crc == chk_crc);
        rsp_val_o    = {rsp_len_i[14], rsp_len_i[9:0]};
    end
endmodule

// File: rtl/cmd_gap_timer.sv
module cmd_gap_timer #(
    parameter int GAP = 1875
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(GAP + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CW'(GAP - 1));
endmodule

// File: rtl/cmd_issue_seq.sv
module cmd_issue_seq
    import cmd_issue_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter int          CTRL_ADDR  = 0,
    parameter int          LEN_ADDR   = 1,
    parameter int          POLL_GAP   = 1875,
    parameter int          POLL_LIMIT = 33334
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [12:0]       cmd_id,
    input  logic [9:0]        cmd_len,
    input  logic              crc_clr,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [10:0]       result,
    output logic              crc_latched,
    output logic              shutdown_req,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [15:0]       bus_rdata
);
    localparam int PCW = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [15:0]    enc_ctrl;
        logic [15:0]    enc_len;
        logic [15:0]    rsp_ctrl;
        logic [PCW-1:0] npoll;
        logic           done;
        cmd_status_e    status;
        logic [10:0]    result;
        logic           latched;
        logic           shut;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [15:0] enc_ctrl_w, enc_len_w;
    logic        rsp_ok_w;
    logic [10:0] rsp_val_w;
    logic        gap_run, gap_done;

    cmd_crc6_codec u_codec (
        .id_i       (cmd_id),
        .len_i      (cmd_len),
        .rsp_ctrl_i (q.rsp_ctrl),
        .rsp_len_i  (bus_rdata),
        .enc_ctrl_o (enc_ctrl_w),
        .enc_len_o  (enc_len_w),
        .rsp_ok_o   (rsp_ok_w),
        .rsp_val_o  (rsp_val_w)
    );

    assign gap_run = (q.st == SQ_GAP);

    cmd_gap_timer #(.GAP(POLL_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gap_run),
        .expired (gap_done)
    );

    always_comb begin
        logic        fin;
        logic        evt;
        cmd_status_e fin_sts;
        logic [10:0] fin_res;

        d        = q;
        d.done   = 1'b0;
        d.shut   = 1'b0;
        fin      = 1'b0;
        evt      = 1'b0;
        fin_sts  = STS_OK;
        fin_res  = '0;

        if (crc_clr) d.latched = 1'b0;

        unique case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    d.enc_ctrl = enc_ctrl_w;
                    d.enc_len  = enc_len_w;
                    d.npoll    = '0;
                    d.st       = SQ_WR_LEN;
                end
            end
            SQ_WR_LEN: if (bus_ack) begin
                if (bus_err) begin fin = 1'b1; fin_sts = STS_BUS; end
                else d.st = SQ_WR_CTRL;
            end
            SQ_WR_CTRL: if (bus_ack) begin
                if (bus_err) begin fin = 1'b1; fin_sts = STS_BUS; end
                else d.st = SQ_GAP;
            end
            SQ_GAP: if (gap_done) d.st = SQ_POLL;
            SQ_POLL: if (bus_ack) begin
                if (bus_err) begin
                    fin = 1'b1; fin_sts = STS_BUS;
                end else if (!bus_rdata[15]) begin
                    d.st = SQ_RD_CTRL;
                end else if (q.npoll == PCW'(POLL_LIMIT - 1)) begin
                    fin = 1'b1; fin_sts = STS_TMO;
                end else begin
                    d.npoll = q.npoll + 1'b1;
                    d.st    = SQ_GAP;
                end
            end
            SQ_RD_CTRL: if (bus_ack) begin
                if (bus_err) begin fin = 1'b1; fin_sts = STS_BUS; end
                else begin
                    d.rsp_ctrl = bus_rdata;
                    d.st       = SQ_RD_LEN;
                end
            end
            SQ_RD_LEN: if (bus_ack) begin
                fin = 1'b1;
                if (bus_err) begin
                    fin_sts = STS_BUS;
                end else if (!rsp_ok_w) begin
                    fin_sts = STS_CRC;
                    evt     = 1'b1;
                end else begin
                    fin_res = rsp_val_w;
                    evt     = (rsp_val_w == FW_CMD_CRC_BAD) || (rsp_val_w == FW_PAY_CRC_BAD);
                end
            end
            default: d.st = SQ_IDLE;
        endcase

        if (fin) begin
            d.st     = SQ_IDLE;
            d.done   = 1'b1;
            d.status = fin_sts;
            d.result = fin_res;
            if (evt) begin
                d.shut    = !q.latched;
                d.latched = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= SQ_IDLE;
            q.status   <= STS_OK;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = ADDR_W'(CTRL_ADDR);
        bus_wdata = '0;
        unique case (q.st)
            SQ_WR_LEN: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = ADDR_W'(LEN_ADDR); bus_wdata = q.enc_len;
            end
            SQ_WR_CTRL: begin
                bus_req = 1'b1; bus_we = 1'b1; bus_wdata = q.enc_ctrl;
            end
            SQ_POLL, SQ_RD_CTRL: bus_req = 1'b1;
            SQ_RD_LEN: begin
                bus_req = 1'b1; bus_addr = ADDR_W'(LEN_ADDR);
            end
            default: ;
        endcase
    end

    assign busy         = (q.st != SQ_IDLE);
    assign done         = q.done;
    assign status       = q.status;
    assign result       = q.result;
    assign crc_latched  = q.latched;
    assign shutdown_req = q.shut;
endmodule

// File: rtl/cmd_issue_seq_chk.sv
module cmd_issue_seq_chk #(
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              crc_clr,
    input logic              crc_latched,
    input logic              shutdown_req,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_ack
);
    p_idle_noreq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_W'(CTRL_ADDR)) |-> bus_wdata[15]);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    p_shut_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> (done && crc_latched));

    p_shut_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> !$past(crc_latched));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_latched && !crc_clr) |=> crc_latched);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        crc_clr |=> (!crc_latched || done));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind cmd_issue_seq cmd_issue_seq_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .crc_clr      (crc_clr),
    .crc_latched  (crc_latched),
    .shutdown_req (shutdown_req),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_ack      (bus_ack)
);

// File: tb/cmd_issue_seq_bench.sv
module cmd_issue_seq_bench;
    localparam int ADDR_W = 5;
    localparam int GAP    = 4;
    localparam int LIMIT  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [12:0] cmd_id = '0;
    logic [9:0]  cmd_len = '0;
    logic crc_clr = 1'b0;
    logic busy, done, crc_latched, shutdown_req;
    logic [1:0] status;
    logic [10:0] result;
    logic bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [15:0] bus_wdata;
    logic bus_ack = 1'b0;
    logic bus_err = 1'b0;
    logic [15:0] bus_rdata = '0;

    always #4 clk = ~clk;

    cmd_issue_seq #(.ADDR_W(ADDR_W), .POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) u_cmd_issue_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_id(cmd_id), .cmd_len(cmd_len),
        .crc_clr(crc_clr), .busy(busy), .done(done), .status(status), .result(result),
        .crc_latched(crc_latched), .shutdown_req(shutdown_req), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .bus_rdata(bus_rdata));

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent bit-serial CRC-6 model (poly 0x2F, init 0)
    function automatic logic [5:0] ref_crc6(input logic [15:0] c, input logic [9:0] l);
        logic [31:0] dat;
        logic [5:0]  crc;
        logic        fb;
        dat = {6'b0, l, c};
        crc = 6'd0;
        for (int b = 0; b < 4; b++) begin
            for (int k = 7; k >= 0; k--) begin
                fb  = crc[5] ^ dat[8*b + k];
                crc = {crc[4:0], 1'b0};
                if (fb) crc = crc ^ 6'h2F;
            end
        end
        return crc;
    endfunction

    // ---------------- slave model ----------------
    int          cfg_busy = 0;
    logic [10:0] cfg_ret = '0;
    bit          cfg_corrupt = 0, cfg_hang = 0, cfg_err = 0;
    logic [15:0] exp_len_w, exp_ctrl_w;
    int n_len_wr = 0, n_ctrl_wr = 0, n_ctrl_rd = 0;
    int busy_left = 0;
    logic [15:0] rsp_ctrl, rsp_len;
    int cyc = 0, last_busy_rd = -1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            bus_err <= 1'b0;
            if (bus_we) begin
                if (cfg_err) begin
                    bus_err <= 1'b1;
                    if (bus_addr == 5'd1) n_len_wr++;
                    else n_ctrl_wr++;
                end else if (bus_addr == 5'd1) begin
                    n_len_wr++;
                    chk(bus_wdata == exp_len_w, "R2 length word", {16'h0, bus_wdata}, {16'h0, exp_len_w});
                end else begin
                    logic [15:0] orig;
                    logic [5:0]  rc;
                    n_ctrl_wr++;
                    chk(n_len_wr == 1, "R2 length written before control", n_len_wr, 1);
                    chk(bus_wdata == exp_ctrl_w, "R3 control word", {16'h0, bus_wdata}, {16'h0, exp_ctrl_w});
                    busy_left = cfg_busy;
                    orig = {1'b0, cfg_ret[10], 1'b1, bus_wdata[12:0]};
                    rc   = ref_crc6(orig, cfg_ret[9:0]);
                    rsp_ctrl = {1'b0, rc[5:4], bus_wdata[12:0]};
                    rsp_len  = {1'b1, cfg_ret[10], rc[3:0], cfg_ret[9:0]};
                    if (cfg_corrupt) rsp_len[12] = ~rsp_len[12];
                end
            end else if (bus_addr == 5'd0) begin
                n_ctrl_rd++;
                if (last_busy_rd >= 0)
                    chk(cyc - last_busy_rd >= GAP, "R4 poll gap", cyc - last_busy_rd, GAP);
                if (cfg_hang || busy_left > 0) begin
                    bus_rdata <= 16'h8000 | rsp_ctrl;
                    if (busy_left > 0) busy_left--;
                    last_busy_rd = cyc;
                end else begin
                    bus_rdata <= rsp_ctrl;
                    last_busy_rd = -1;
                end
            end else begin
                bus_rdata <= rsp_len;
            end
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { logic [1:0] sts; logic [10:0] res; bit sh; bit lat; string tag; } exp_t;
    exp_t exp_q[$];
    int n_done = 0;

    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (exp_q.size() == 0) begin
                chk(0, "R13 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(status == e.sts, {e.tag, " status"}, status, e.sts);
                chk(result == e.res, {e.tag, " result"}, result, e.res);
                chk(shutdown_req == e.sh, {e.tag, " R9 shutdown_req"}, shutdown_req, e.sh);
                chk(crc_latched == e.lat, {e.tag, " R9 crc_latched"}, crc_latched, e.lat);
            end
        end
    end

    task automatic run_cmd(input logic [12:0] id, input logic [9:0] len, input logic [10:0] ret,
                           input int nbusy, input bit corrupt, input bit hang, input bit berr, input bit stray,
                           input logic [1:0] ests, input logic [10:0] eres, input bit esh, input bit elat,
                           input string tag);
        exp_t e;
        logic [5:0] c;
        int d0;
        c = ref_crc6({3'b111, id}, len);
        exp_len_w  = {2'b11, c[3:0], len};
        exp_ctrl_w = {1'b1, c[5:4], id};
        cfg_ret = ret; cfg_busy = nbusy; cfg_corrupt = corrupt; cfg_hang = hang; cfg_err = berr;
        n_len_wr = 0; n_ctrl_wr = 0; n_ctrl_rd = 0; last_busy_rd = -1;
        e.sts = ests; e.res = eres; e.sh = esh; e.lat = elat; e.tag = tag;
        exp_q.push_back(e);
        d0 = n_done;
        @(negedge clk);
        cmd_id = id; cmd_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R13 busy after start", busy, 1);
        if (stray) begin
            repeat (3) @(negedge clk);
            cmd_id = 13'h0077; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (n_done == d0) @(negedge clk);
        repeat (12) @(negedge clk);
        if (stray) begin
            chk(n_done == d0 + 1, "R11 single done", n_done - d0, 1);
            chk(n_ctrl_wr == 1, "R11 single control write", n_ctrl_wr, 1);
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        crc_clr = 1'b1;
        @(negedge clk);
        crc_clr = 1'b0;
        chk(crc_latched == 1'b0, "R10 latch cleared", crc_latched, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && bus_req == 0, "R1 reset outputs", {busy, done, bus_req}, 0);
        chk(crc_latched == 0 && shutdown_req == 0, "R1 reset latch", {crc_latched, shutdown_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_cmd(13'h0123, 10'd40, 11'd5, 2, 0, 0, 0, 0, 2'd0, 11'd5, 0, 0, "R6 positive result");
        run_cmd(13'h1FFF, 10'd1023, 11'h7EA, 0, 0, 0, 0, 0, 2'd0, 11'h7EA, 0, 0, "R6 negative result");
        run_cmd(13'h0045, 10'd7, 11'd3, 1, 1, 0, 0, 0, 2'd1, 11'd0, 1, 1, "R7 reply mismatch");
        run_cmd(13'h0046, 10'd2, 11'h400, 0, 0, 0, 0, 0, 2'd0, 11'h400, 0, 1, "R9 code while latched");
        chk(crc_latched == 1'b1, "R10 latch sticky", crc_latched, 1);
        pulse_clr();
        run_cmd(13'h0047, 10'd9, 11'h401, 1, 0, 0, 0, 0, 2'd0, 11'h401, 1, 1, "R9 payload code");
        pulse_clr();
        run_cmd(13'h0010, 10'd4, 11'd0, 0, 0, 1, 0, 0, 2'd2, 11'd0, 0, 0, "R5 timeout");
        chk(n_ctrl_rd == LIMIT, "R5 poll count", n_ctrl_rd, LIMIT);
        run_cmd(13'h0011, 10'd4, 11'd1, 0, 0, 0, 1, 0, 2'd3, 11'd0, 0, 0, "R8 bus error");
        chk(n_ctrl_wr == 0 && n_len_wr == 1, "R8 abort after error", {n_len_wr[15:0], n_ctrl_wr[15:0]}, 32'h00010000);
        run_cmd(13'h0008, 10'd0, 11'd0, 1, 0, 0, 0, 0, 2'd0, 11'd0, 0, 0, "R12 zero-length reset command");
        run_cmd(13'h0222, 10'd16, 11'd9, 3, 0, 0, 0, 1, 2'd0, 11'd9, 0, 0, "R11 start while busy");
        chk(exp_q.size() == 0, "R13 all completions seen", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule